// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns the phase A and phase B signals of an incremental shaft encoder, plus an index pulse and a home switch, into a signed 32-bit position count, a 16-bit revolution count and a 16-bit difference count. All four inputs are synchronized and passed through a programmable stability filter. Decoding is either full quadrature, with four counts per cycle, or single-phase, where A is a count pulse and B gives the direction.

Software reaches the block through a 16-bit register port with a 5-bit word address. A read strobe on the upper position word copies the lower position word, the difference count and the revolution count into hold registers in the same cycle. This lets a 32-bit value be read coherently over the narrow port. The position can be loaded from a 32-bit start value by a software command, by an index edge or by a home edge. It can also wrap between the start value and a 32-bit limit. A compare value flags a match. Five sticky flags, each with an enable, drive one interrupt line.

Top module: `qdec_pos_counter`

## Requirements
- R1: After reset the position reads 0, both compare words (addresses 7 upper, 8 lower) read 0xFFFF, the control words read 0 and `irq` is low.
- R2: In quadrature mode the filtered pair {A,B} stepping 00→10→11→01→00 adds 1 to the position per step, and the opposite order subtracts 1. Control bit 0 (direction invert) swaps the two.
- R3: A change of both A and B between two filtered samples leaves the position and the difference count unchanged.
- R4: Control bit 1 selects single-phase mode. Each rising edge of A counts up when B is 0 and down when B is 1, and bit 0 still inverts the direction.
- R5: Filter word (address 2) bits [3:0] hold N and bits [11:4] hold P. An input change is accepted only after N+1 consecutive differing samples, taken every P+1 clocks. A shorter pulse has no effect.
- R6: Writing 1 to control bit 6 loads the position from the start value (address 3 upper, 4 lower). Bit 6 always reads back 0.
- R7: A read strobe on the upper position word (address 9) returns the live upper half. In the same cycle it captures the lower position (address 12), the difference count (address 14) and the revolution count (address 16), and it restarts the difference count.
- R8: With control-2 (address 1) bit 0 set, an up step from the limit (address 5 upper, 6 lower) loads the start value and sets the roll-over flag (control-2 bit 2). A down step from the start value loads the limit and sets the roll-under flag (control-2 bit 4).
- R9: The compare flag (control bit 12) is set while the position equals the compare value.
- R10: An index edge sets the index flag (control bit 8). The edge is rising, or falling when control bit 3 is 1. When control bit 2 is 1 the edge also loads the start value. Each index edge moves the revolution count (address 15) by +1 or −1 according to the direction of the latest step.
- R11: A home edge sets the home flag (control bit 10). The edge is rising, or falling when control bit 5 is 1. When control bit 4 is 1 the edge also loads the start value.
- R12: Writing 1 to a flag bit clears it, and writing 0 leaves it. `irq` is high exactly when some flag is set together with its enable: index bit 7, home bit 9, compare bit 11, roll-over control-2 bit 1, roll-under control-2 bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (needed for the snapshot side effect) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ph_a | input | 1 | Encoder phase A |
| ph_b | input | 1 | Encoder phase B |
| idx_in | input | 1 | Index pulse |
| home_in | input | 1 | Home switch |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:
- **Double-bit transition.** A design that decodes it as a step would drift the position by one.
- **Glitch shorter than the filter window.** A filter that accepts it gives a spurious single-phase count.
- **Index edge of the wrong polarity.** A design that ignores the polarity bit would reload the position and bump the revolution count too early.
- **Modulo boundaries in both directions.** A wrong compare at the limit or the start value either overruns the range or sets the wrong flag.
- **Interrupt masking and write-1-to-clear.** The bench checks that a roll-under flag with its enable off keeps the interrupt low, and that clearing one flag leaves the others untouched.
- **Difference count after a snapshot.** It must show only the net steps since the previous upper-word read.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int AW = 5;

  // register word addresses
  localparam logic [AW-1:0] A_CTL     = 5'd0;
  localparam logic [AW-1:0] A_CTL2    = 5'd1;
  localparam logic [AW-1:0] A_FLT     = 5'd2;
  localparam logic [AW-1:0] A_INIT_HI = 5'd3;
  localparam logic [AW-1:0] A_INIT_LO = 5'd4;
  localparam logic [AW-1:0] A_LIM_HI  = 5'd5;
  localparam logic [AW-1:0] A_LIM_LO  = 5'd6;
  localparam logic [AW-1:0] A_CMP_HI  = 5'd7;
  localparam logic [AW-1:0] A_CMP_LO  = 5'd8;
  localparam logic [AW-1:0] A_POS_HI  = 5'd9;
  localparam logic [AW-1:0] A_POS_LO  = 5'd10;
  localparam logic [AW-1:0] A_HPOS_HI = 5'd11;
  localparam logic [AW-1:0] A_HPOS_LO = 5'd12;
  localparam logic [AW-1:0] A_DIFF    = 5'd13;
  localparam logic [AW-1:0] A_HDIFF   = 5'd14;
  localparam logic [AW-1:0] A_REVS    = 5'd15;
  localparam logic [AW-1:0] A_HREVS   = 5'd16;

  // control word bit positions
  localparam int B_INV    = 0;
  localparam int B_SINGLE = 1;
  localparam int B_IXLD   = 2;
  localparam int B_IXFALL = 3;
  localparam int B_HMLD   = 4;
  localparam int B_HMFALL = 5;
  localparam int B_SWLD   = 6;
  localparam int B_IXIE   = 7;
  localparam int B_IXF    = 8;
  localparam int B_HMIE   = 9;
  localparam int B_HMF    = 10;
  localparam int B_CMPIE  = 11;
  localparam int B_CMPF   = 12;

  // control-2 word bit positions
  localparam int B_WRAP   = 0;
  localparam int B_ROIE   = 1;
  localparam int B_ROF    = 2;
  localparam int B_RUIE   = 3;
  localparam int B_RUF    = 4;

  // filtered input lane order
  localparam int L_A    = 0;
  localparam int L_B    = 1;
  localparam int L_IDX  = 2;
  localparam int L_HOME = 3;
  localparam int LANES  = 4;
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int N      = 4,
  parameter int CNT_W  = 4,
  parameter int PER_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     raw,
  input  logic [CNT_W-1:0] need,
  input  logic [PER_W-1:0] period,
  output logic [N-1:0]     clean
);
  logic [N-1:0]     sync1_q, sync2_q;
  logic [PER_W-1:0] tick_cnt_q, tick_cnt_n;
  logic             tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
    end
  end

  assign tick = (tick_cnt_q >= period);

  always_comb begin
    tick_cnt_n = tick ? '0 : tick_cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt_q <= '0;
    else        tick_cnt_q <= tick_cnt_n;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [CNT_W-1:0] run_q, run_n;
    logic             out_q, out_n;

    always_comb begin
      run_n = run_q;
      out_n = out_q;
      if (tick) begin
        if (sync2_q[g] != out_q) begin
          if (run_q == need) begin
            out_n = sync2_q[g];
            run_n = '0;
          end else begin
            run_n = run_q + CNT_W'(1);
          end
        end else begin
          run_n = '0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= '0;
        out_q <= 1'b0;
      end else begin
        run_q <= run_n;
        out_q <= out_n;
      end
    end

    assign clean[g] = out_q;
  end
endmodule

// File: rtl/qdec_step.sv
module qdec_step (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic single,
  input  logic invert,
  output logic up,
  output logic dn
);
  logic prev_a_q, prev_b_q;
  logic fwd, bwd, rise_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
    end else begin
      prev_a_q <= a;
      prev_b_q <= b;
    end
  end

  assign rise_a = a & ~prev_a_q;

  always_comb begin
    if (single) begin
      fwd = rise_a & ~b;
      bwd = rise_a & b;
    end else begin
      // Gray order 00 -> 10 -> 11 -> 01 ; double changes match neither
      fwd = ({a, b} == {~prev_b_q, prev_a_q});
      bwd = ({a, b} == {prev_b_q, ~prev_a_q});
    end
    up = invert ? bwd : fwd;
    dn = invert ? fwd : bwd;
  end
endmodule

// File: rtl/qdec_count.sv
module qdec_count #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up,
  input  logic            dn,
  input  logic            load,
  input  logic            wrap_en,
  input  logic            idx_evt,
  input  logic            snap,
  input  logic [2*DW-1:0] start_val,
  input  logic [2*DW-1:0] lim_val,
  output logic [2*DW-1:0] pos,
  output logic [DW-1:0]   diff,
  output logic [DW-1:0]   revs,
  output logic            ro_evt,
  output logic            ru_evt
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] pos_q, pos_n;
  logic [DW-1:0] diff_q, diff_n, revs_q, revs_n, diff_base;
  logic          last_up_q, last_up_n, dir_up;

  always_comb begin
    pos_n  = pos_q;
    ro_evt = 1'b0;
    ru_evt = 1'b0;
    if (load) begin
      pos_n = start_val;
    end else if (up) begin
      if (wrap_en && pos_q == lim_val) begin
        pos_n  = start_val;
        ro_evt = 1'b1;
      end else begin
        pos_n  = pos_q + PW'(1);
        ro_evt = !wrap_en && (pos_q == '1);
      end
    end else if (dn) begin
      if (wrap_en && pos_q == start_val) begin
        pos_n  = lim_val;
        ru_evt = 1'b1;
      end else begin
        pos_n  = pos_q - PW'(1);
        ru_evt = !wrap_en && (pos_q == '0);
      end
    end

    diff_base = snap ? '0 : diff_q;
    if (!load && up)      diff_n = diff_base + DW'(1);
    else if (!load && dn) diff_n = diff_base - DW'(1);
    else                  diff_n = diff_base;

    last_up_n = up ? 1'b1 : (dn ? 1'b0 : last_up_q);
    dir_up    = last_up_n;
    if (idx_evt) revs_n = dir_up ? revs_q + DW'(1) : revs_q - DW'(1);
    else         revs_n = revs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      diff_q    <= '0;
      revs_q    <= '0;
      last_up_q <= 1'b1;
    end else begin
      pos_q     <= pos_n;
      diff_q    <= diff_n;
      revs_q    <= revs_n;
      last_up_q <= last_up_n;
    end
  end

  assign pos  = pos_q;
  assign diff = diff_q;
  assign revs = revs_q;
endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
  import qdec_pkg::*;
#(
  parameter int DW     = 16,
  parameter int FCNT_W = 4,
  parameter int FPER_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ph_a,
  input  logic          ph_b,
  input  logic          idx_in,
  input  logic          home_in,
  output logic          irq
);
  localparam int PW = 2 * DW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  // write decodes
  logic wr_ctl, wr_ctl2, wr_flt, snap;
  assign wr_ctl  = reg_wr && (reg_addr == A_CTL);
  assign wr_ctl2 = reg_wr && (reg_addr == A_CTL2);
  assign wr_flt  = reg_wr && (reg_addr == A_FLT);
  assign snap    = reg_rd && (reg_addr == A_POS_HI);

  // configuration registers
  logic [5:0]        cfg_q;
  logic              ix_ie_q, hm_ie_q, cmp_ie_q, wrap_q, ro_ie_q, ru_ie_q;
  logic [FCNT_W-1:0] f_need_q;
  logic [FPER_W-1:0] f_per_q;
  logic [DW-1:0]     start_hi_q, start_lo_q, lim_hi_q, lim_lo_q, cmp_hi_q, cmp_lo_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfg_q <= '0; ix_ie_q <= 1'b0; hm_ie_q <= 1'b0; cmp_ie_q <= 1'b0;
      wrap_q <= 1'b0; ro_ie_q <= 1'b0; ru_ie_q <= 1'b0;
      f_need_q <= '0; f_per_q <= '0;
      start_hi_q <= '0; start_lo_q <= '0; lim_hi_q <= '0; lim_lo_q <= '0;
      cmp_hi_q <= '1; cmp_lo_q <= '1;
    end else begin
      if (wr_ctl) begin
        cfg_q    <= reg_wdata[5:0];
        ix_ie_q  <= reg_wdata[B_IXIE];
        hm_ie_q  <= reg_wdata[B_HMIE];
        cmp_ie_q <= reg_wdata[B_CMPIE];
      end
      if (wr_ctl2) begin
        wrap_q  <= reg_wdata[B_WRAP];
        ro_ie_q <= reg_wdata[B_ROIE];
        ru_ie_q <= reg_wdata[B_RUIE];
      end
      if (wr_flt) begin
        f_need_q <= reg_wdata[FCNT_W-1:0];
        f_per_q  <= reg_wdata[FCNT_W+FPER_W-1:FCNT_W];
      end
      if (reg_wr && reg_addr == A_INIT_HI) start_hi_q <= reg_wdata;
      if (reg_wr && reg_addr == A_INIT_LO) start_lo_q <= reg_wdata;
      if (reg_wr && reg_addr == A_LIM_HI)  lim_hi_q   <= reg_wdata;
      if (reg_wr && reg_addr == A_LIM_LO)  lim_lo_q   <= reg_wdata;
      if (reg_wr && reg_addr == A_CMP_HI)  cmp_hi_q   <= reg_wdata;
      if (reg_wr && reg_addr == A_CMP_LO)  cmp_lo_q   <= reg_wdata;
    end
  end

  logic [PW-1:0] start_val, lim_val, cmp_val;
  assign start_val = {start_hi_q, start_lo_q};
  assign lim_val   = {lim_hi_q, lim_lo_q};
  assign cmp_val   = {cmp_hi_q, cmp_lo_q};

  // input conditioning
  logic [LANES-1:0] clean;
  qdec_filter #(.N(LANES), .CNT_W(FCNT_W), .PER_W(FPER_W)) u_filter (
    .clk(clk), .rst_n(rst_s),
    .raw({home_in, idx_in, ph_b, ph_a}),
    .need(f_need_q), .period(f_per_q), .clean(clean)
  );

  // index / home edge events
  logic ix_d_q, hm_d_q, ix_evt, hm_evt;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ix_d_q <= 1'b0;
      hm_d_q <= 1'b0;
    end else begin
      ix_d_q <= clean[L_IDX];
      hm_d_q <= clean[L_HOME];
    end
  end
  assign ix_evt = cfg_q[B_IXFALL] ? (ix_d_q & ~clean[L_IDX])  : (~ix_d_q & clean[L_IDX]);
  assign hm_evt = cfg_q[B_HMFALL] ? (hm_d_q & ~clean[L_HOME]) : (~hm_d_q & clean[L_HOME]);

  // step decode and counters
  logic step_up, step_dn, load;
  qdec_step u_step (
    .clk(clk), .rst_n(rst_s), .a(clean[L_A]), .b(clean[L_B]),
    .single(cfg_q[B_SINGLE]), .invert(cfg_q[B_INV]), .up(step_up), .dn(step_dn)
  );

  assign load = (wr_ctl && reg_wdata[B_SWLD]) || (ix_evt && cfg_q[B_IXLD]) ||
                (hm_evt && cfg_q[B_HMLD]);

  logic [PW-1:0] pos;
  logic [DW-1:0] diff, revs;
  logic          ro_evt, ru_evt;
  qdec_count #(.DW(DW)) u_count (
    .clk(clk), .rst_n(rst_s), .up(step_up), .dn(step_dn), .load(load),
    .wrap_en(wrap_q), .idx_evt(ix_evt), .snap(snap),
    .start_val(start_val), .lim_val(lim_val),
    .pos(pos), .diff(diff), .revs(revs), .ro_evt(ro_evt), .ru_evt(ru_evt)
  );

  // sticky flags, write-1-to-clear, set wins
  logic ix_f_q, hm_f_q, cmp_f_q, ro_f_q, ru_f_q;
  logic ix_f_n, hm_f_n, cmp_f_n, ro_f_n, ru_f_n;
  always_comb begin
    ix_f_n  = ix_evt         | (ix_f_q  & ~(wr_ctl  & reg_wdata[B_IXF]));
    hm_f_n  = hm_evt         | (hm_f_q  & ~(wr_ctl  & reg_wdata[B_HMF]));
    cmp_f_n = (pos == cmp_val) | (cmp_f_q & ~(wr_ctl  & reg_wdata[B_CMPF]));
    ro_f_n  = ro_evt         | (ro_f_q  & ~(wr_ctl2 & reg_wdata[B_ROF]));
    ru_f_n  = ru_evt         | (ru_f_q  & ~(wr_ctl2 & reg_wdata[B_RUF]));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ix_f_q <= 1'b0; hm_f_q <= 1'b0; cmp_f_q <= 1'b0; ro_f_q <= 1'b0; ru_f_q <= 1'b0;
    end else begin
      ix_f_q <= ix_f_n; hm_f_q <= hm_f_n; cmp_f_q <= cmp_f_n; ro_f_q <= ro_f_n; ru_f_q <= ru_f_n;
    end
  end

  assign irq = (ix_f_q & ix_ie_q) | (hm_f_q & hm_ie_q) | (cmp_f_q & cmp_ie_q) |
               (ro_f_q & ro_ie_q) | (ru_f_q & ru_ie_q);

  // snapshot holds
  logic [DW-1:0] h_pos_hi_q, h_pos_lo_q, h_diff_q, h_revs_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      h_pos_hi_q <= '0; h_pos_lo_q <= '0; h_diff_q <= '0; h_revs_q <= '0;
    end else if (snap) begin
      h_pos_hi_q <= pos[PW-1:DW];
      h_pos_lo_q <= pos[DW-1:0];
      h_diff_q   <= diff;
      h_revs_q   <= revs;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL: begin
        reg_rdata[5:0]     = cfg_q;
        reg_rdata[B_IXIE]  = ix_ie_q;
        reg_rdata[B_IXF]   = ix_f_q;
        reg_rdata[B_HMIE]  = hm_ie_q;
        reg_rdata[B_HMF]   = hm_f_q;
        reg_rdata[B_CMPIE] = cmp_ie_q;
        reg_rdata[B_CMPF]  = cmp_f_q;
      end
      A_CTL2: begin
        reg_rdata[B_WRAP] = wrap_q;
        reg_rdata[B_ROIE] = ro_ie_q;
        reg_rdata[B_ROF]  = ro_f_q;
        reg_rdata[B_RUIE] = ru_ie_q;
        reg_rdata[B_RUF]  = ru_f_q;
      end
      A_FLT:     reg_rdata[FCNT_W+FPER_W-1:0] = {f_per_q, f_need_q};
      A_INIT_HI: reg_rdata = start_hi_q;
      A_INIT_LO: reg_rdata = start_lo_q;
      A_LIM_HI:  reg_rdata = lim_hi_q;
      A_LIM_LO:  reg_rdata = lim_lo_q;
      A_CMP_HI:  reg_rdata = cmp_hi_q;
      A_CMP_LO:  reg_rdata = cmp_lo_q;
      A_POS_HI:  reg_rdata = pos[PW-1:DW];
      A_POS_LO:  reg_rdata = pos[DW-1:0];
      A_HPOS_HI: reg_rdata = h_pos_hi_q;
      A_HPOS_LO: reg_rdata = h_pos_lo_q;
      A_DIFF:    reg_rdata = diff;
      A_HDIFF:   reg_rdata = h_diff_q;
      A_REVS:    reg_rdata = revs;
      A_HREVS:   reg_rdata = h_revs_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdec_pos_counter_chk.sv
module qdec_pos_counter_chk #(
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ctl,
  input logic          wr_ctl2,
  input logic          sw_bit,
  input logic          ro_clr_bit,
  input logic          snap,
  input logic          load,
  input logic          wrap_en,
  input logic          ro_evt,
  input logic          ro_flag,
  input logic          any_ie,
  input logic          irq,
  input logic [PW-1:0] pos,
  input logic [PW-1:0] start_val,
  input logic [PW/2-1:0] hold_lo
);
  AST_SWINIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && sw_bit) |=> (pos == $past(start_val))); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wrap_en) |=> (pos == $past(pos) || pos == $past(pos) + PW'(1) ||
                            pos == $past(pos) - PW'(1))); // R2

  AST_SNAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (hold_lo == $past(pos[PW/2-1:0]))); // R7

  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && ro_evt) |=> (pos == $past(start_val))); // R8

  AST_RO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl2 && ro_clr_bit && !ro_evt) |=> !ro_flag); // R12

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ie |-> !irq); // R12
endmodule

bind qdec_pos_counter qdec_pos_counter_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_s),
  .wr_ctl(wr_ctl), .wr_ctl2(wr_ctl2),
  .sw_bit(reg_wdata[6]), .ro_clr_bit(reg_wdata[2]),
  .snap(snap), .load(load), .wrap_en(wrap_q),
  .ro_evt(ro_evt), .ro_flag(ro_f_q),
  .any_ie(ix_ie_q | hm_ie_q | cmp_ie_q | ro_ie_q | ru_ie_q),
  .irq(irq), .pos(pos), .start_val(start_val), .hold_lo(h_pos_lo_q)
);

// File: tb/qdec_pos_counter_tb.sv
module qdec_pos_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0, home_in = 1'b0;
  logic        irq;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  qdec_pos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ph_a(ph_a), .ph_b(ph_b),
    .idx_in(idx_in), .home_in(home_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_pos(output logic [31:0] p);
    logic [15:0] hi, lo;
    rd(5'd9, hi);
    rd(5'd12, lo);
    p = {hi, lo};
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic fwd(input int n);
    for (int i = 0; i < n; i++) begin
      {ph_a, ph_b} = {~ph_b, ph_a};
      settle();
    end
  endtask

  task automatic bwd(input int n);
    for (int i = 0; i < n; i++) begin
      {ph_a, ph_b} = {ph_b, ~ph_a};
      settle();
    end
  endtask

  task automatic pulse_a(input int len);
    ph_a = 1'b1;
    repeat (len) @(negedge clk);
    ph_a = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    logic [15:0] d; logic [31:0] p;
    rd(5'd7, d);  chk("R1 cmp hi", {16'h0, d}, 32'hFFFF);
    rd(5'd8, d);  chk("R1 cmp lo", {16'h0, d}, 32'hFFFF);
    rd(5'd0, d);  chk("R1 ctl", {16'h0, d}, 32'h0);
    read_pos(p);  chk("R1 pos", p, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_quad();
    logic [31:0] p; logic [15:0] d;
    read_pos(p);
    fwd(6); bwd(2);
    read_pos(p);  chk("R2 fwd6 bwd2", p, 32'd4);
    rd(5'd14, d); chk("R7 diff hold", {16'h0, d}, 32'd4);
    wr(5'd0, 16'h0001);
    fwd(4);
    read_pos(p);  chk("R2 inverted", p, 32'd0);
    wr(5'd0, 16'h0000);
  endtask

  task automatic t_illegal();
    logic [31:0] p; logic [15:0] d;
    ph_a = 1'b1; ph_b = 1'b1; settle();
    ph_a = 1'b0; ph_b = 1'b0; settle();
    read_pos(p);  chk("R3 pos", p, 32'd0);
    rd(5'd14, d); chk("R3 diff", {16'h0, d}, 32'd0);
  endtask

  task automatic t_single();
    logic [31:0] p;
    wr(5'd0, 16'h0002);
    pulse_a(4); pulse_a(4); pulse_a(4);
    ph_b = 1'b1; settle();
    pulse_a(4);
    ph_b = 1'b0; settle();
    read_pos(p);  chk("R4 single", p, 32'd2);
  endtask

  task automatic t_filter();
    logic [31:0] p;
    wr(5'd2, 16'h0003);
    pulse_a(2);
    read_pos(p);  chk("R5 glitch", p, 32'd2);
    pulse_a(12);
    read_pos(p);  chk("R5 long pulse", p, 32'd3);
    wr(5'd2, 16'h0000);
    wr(5'd0, 16'h0000);
  endtask

  task automatic t_swinit();
    logic [31:0] p; logic [15:0] d;
    wr(5'd3, 16'h0001); wr(5'd4, 16'h2345);
    wr(5'd0, 16'h0040);
    read_pos(p);  chk("R6 load", p, 32'h12345);
    rd(5'd0, d);  chk("R6 bit clear", {16'h0, d}, 32'h0);
    wr(5'd0, 16'h0000);
  endtask

  task automatic t_index();
    logic [31:0] p; logic [15:0] d;
    wr(5'd0, 16'h008C);           // load on index, falling edge, index irq enable
    fwd(1);
    idx_in = 1'b1; settle();
    read_pos(p);  chk("R10 rising ignored", p, 32'h12346);
    rd(5'd0, d);  chk("R10 no flag", {31'h0, d[8]}, 32'h0);
    idx_in = 1'b0; settle();
    read_pos(p);  chk("R10 falling load", p, 32'h12345);
    rd(5'd16, d); chk("R10 rev up", {16'h0, d}, 32'd1);
    rd(5'd0, d);  chk("R10 flag", {31'h0, d[8]}, 32'h1);
    chk("R12 irq index", {31'h0, irq}, 32'h1);
    wr(5'd0, 16'h018C);
    rd(5'd0, d);  chk("R12 w1c", {31'h0, d[8]}, 32'h0);
    chk("R12 irq cleared", {31'h0, irq}, 32'h0);
    bwd(1);
    idx_in = 1'b1; settle(); idx_in = 1'b0; settle();
    rd(5'd15, d); chk("R10 rev down", {16'h0, d}, 32'd0);
    wr(5'd0, 16'h0100);
  endtask

  task automatic t_home();
    logic [31:0] p; logic [15:0] d;
    wr(5'd0, 16'h0010);
    fwd(2);
    home_in = 1'b1; settle();
    read_pos(p);  chk("R11 home load", p, 32'h12345);
    rd(5'd0, d);  chk("R11 flag", {31'h0, d[10]}, 32'h1);
    chk("R12 home masked", {31'h0, irq}, 32'h0);
    home_in = 1'b0; settle();
    fwd(2);
    read_pos(p);  chk("R11 no fall load", p, 32'h12347);
    wr(5'd0, 16'h0400);
  endtask

  task automatic t_wrap();
    logic [31:0] p; logic [15:0] d;
    wr(5'd3, 16'h0000); wr(5'd4, 16'd10);
    wr(5'd5, 16'h0000); wr(5'd6, 16'd13);
    wr(5'd0, 16'h0040);
    wr(5'd1, 16'h0003);
    fwd(3);
    read_pos(p);  chk("R8 at limit", p, 32'd13);
    fwd(1);
    read_pos(p);  chk("R8 rollover", p, 32'd10);
    rd(5'd1, d);  chk("R8 ro flag", {31'h0, d[2]}, 32'h1);
    chk("R12 irq ro", {31'h0, irq}, 32'h1);
    wr(5'd1, 16'h0007);
    rd(5'd1, d);  chk("R12 ro w1c", {31'h0, d[2]}, 32'h0);
    bwd(1);
    read_pos(p);  chk("R8 rollunder", p, 32'd13);
    rd(5'd1, d);  chk("R8 ru flag", {31'h0, d[4]}, 32'h1);
    chk("R12 ru masked", {31'h0, irq}, 32'h0);
    wr(5'd1, 16'h0010);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    wr(5'd7, 16'h0000); wr(5'd8, 16'd15);
    wr(5'd0, 16'h0800);
    fwd(1);
    rd(5'd0, d);  chk("R9 no match", {31'h0, d[12]}, 32'h0);
    fwd(1);
    rd(5'd0, d);  chk("R9 match", {31'h0, d[12]}, 32'h1);
    chk("R12 irq cmp", {31'h0, irq}, 32'h1);
    fwd(1);
    wr(5'd0, 16'h1800);
    rd(5'd0, d);  chk("R9 clear", {31'h0, d[12]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_quad();
    t_illegal();
    t_single();
    t_filter();
    t_swinit();
    t_index();
    t_home();
    t_wrap();
    t_compare();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule